// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns code-fetch, data-read and data-write requests from a processor core into cycles on a 16-bit multiplexed address/data bus. Every cycle has two possible phases. In the address phase the address is placed on the bus and the latch-enable output is high. In the strobe phase the read or write strobe is active. A request is offered with a valid/ready handshake. Completion is reported by a single-cycle done pulse, and for reads the captured word comes back with that pulse.

To save clocks on straight-line code, the sequencer remembers the 16-byte window that the external latch currently holds. A code fetch of the next sequential word inside that window skips the address phase entirely, so up to eight word fetches can follow a single latch cycle. An address phase is issued in four cases: a branch, a fetch that crosses into a new window, the first fetch after reset, and any data access.

Three independent 4-bit length settings give the strobe duration for code reads, data reads and data writes. Slow devices can therefore be served without an external wait-state generator.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, `req_ready` is 1 and `bus_ale`, `bus_rd`, `bus_wr`, `bus_oe` and `done` are all 0.
- R2: The first code fetch after reset always begins with an address phase.
- R3: A code fetch (`req_kind`=2'b00) whose byte address equals the previous code fetch address plus 2 and that lies in the same 16-byte window (equal address bits [15:4]) has no address phase. Its strobe starts in the cycle right after acceptance.
- R4: A sequential code fetch that enters a different 16-byte window begins with an address phase.
- R5: A code fetch whose address is not the previous code fetch address plus 2 begins with an address phase.
- R6: Every data read (`req_kind`=2'b01) and data write (`req_kind`=2'b10 or 2'b11) begins with an address phase. The next code fetch after any data access also begins with one.
- R7: An address phase lasts exactly one clock. During it `bus_out` carries the request address, `bus_oe` is 1 and neither strobe is active. The strobe follows in the next clock.
- R8: The strobe stays active for `cfg_code_len`, `cfg_rd_len` or `cfg_wr_len` clocks, according to the request kind, using the value present at acceptance. A value of 0 gives 1 clock.
- R9: During every write strobe clock, `bus_wr` is 1, `bus_oe` is 1 and `bus_out` equals the request write data. `bus_rd` and `bus_wr` are never both 1.
- R10: For reads, `rdata` during the done pulse equals `bus_in` as sampled at the rising edge that ends the last strobe clock.
- R11: `done` is high for exactly one clock, in the clock right after the last strobe clock. `req_ready` is 0 while an address or strobe phase is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_kind | input | 2 | 00 code fetch, 01 data read, 1x data write |
| req_addr | input | 16 | Byte address (bit 0 ignored) |
| req_wdata | input | 16 | Write data |
| cfg_code_len | input | 4 | Strobe clocks for code reads |
| cfg_rd_len | input | 4 | Strobe clocks for data reads |
| cfg_wr_len | input | 4 | Strobe clocks for data writes |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read word, valid with done |
| bus_ale | output | 1 | Address latch enable |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_out | output | 16 | Value driven onto the multiplexed bus |
| bus_oe | output | 1 | Bus output enable |
| bus_in | input | 16 | Value read from the multiplexed bus |

## Verification
A stale or wrongly cleared window record does not hang the bus. It shows up as an address phase that is missing or extra on the very transaction that follows, and the bench counts latch cycles on every request against its own window model. A miscounted strobe counter shows up as a strobe of the wrong length, or a done pulse off by one clock, in the same transaction. A wrong capture edge gives read data that matches a neighbouring bus value, because the bench changes `bus_in` every clock.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_STRB = 2'd2
    } ebs_state_e;

    // request kind decode: bit1 set = write, else bit0 set = data read, else code
    function automatic logic kind_is_code(input logic [1:0] k);
        return k == 2'b00;
    endfunction

    function automatic logic kind_is_write(input logic [1:0] k);
        return k[1];
    endfunction
endpackage

// File: rtl/ebs_len_sel.sv
module ebs_len_sel #(
    parameter int LW = 4
) (
    input  logic [1:0]    kind,
    input  logic [LW-1:0] cfg_code,
    input  logic [LW-1:0] cfg_rd,
    input  logic [LW-1:0] cfg_wr,
    output logic [LW-1:0] len
);
    logic [LW-1:0] pick;

    always_comb begin
        if (ebs_pkg::kind_is_write(kind))      pick = cfg_wr;
        else if (ebs_pkg::kind_is_code(kind))  pick = cfg_code;
        else                                   pick = cfg_rd;
        // zero is clamped to the one-clock minimum
        len = (pick == '0) ? LW'(1) : pick;
    end
endmodule

// File: rtl/ebs_code_window.sv
module ebs_code_window #(
    parameter int AW        = 16,
    parameter int WIN_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          probe_code,
    input  logic [AW-1:0] probe_addr,
    input  logic          commit,
    output logic          need_ale
);
    localparam int WIN_LSB = $clog2(WIN_BYTES);
    localparam int TAG_W   = AW - WIN_LSB;
    localparam int WA_W    = AW - 1;

    typedef struct packed {
        logic             live;
        logic [TAG_W-1:0] tag;
        logic [WA_W-1:0]  nxt;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        need_ale = !win_q.live
                || !probe_code
                || (probe_addr[AW-1:1] != win_q.nxt)
                || (probe_addr[AW-1:WIN_LSB] != win_q.tag);

        win_d = win_q;
        if (commit) begin
            win_d.live = probe_code;
            win_d.tag  = probe_addr[AW-1:WIN_LSB];
            win_d.nxt  = probe_addr[AW-1:1] + WA_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int LW        = 4,
    parameter int WIN_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [LW-1:0] cfg_code_len,
    input  logic [LW-1:0] cfg_rd_len,
    input  logic [LW-1:0] cfg_wr_len,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          bus_ale,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    input  logic [DW-1:0] bus_in
);
    import ebs_pkg::*;

    typedef struct packed {
        ebs_state_e    st;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [LW-1:0] cnt;
        logic          done;
        logic [DW-1:0] rdata;
    } seq_t;

    seq_t s_d, s_q;

    logic          accept;
    logic          need_ale;
    logic [LW-1:0] len;

    assign req_ready = (s_q.st == ST_IDLE);
    assign accept    = req_valid && req_ready;

    ebs_code_window #(.AW(AW), .WIN_BYTES(WIN_BYTES)) win_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_code (kind_is_code(req_kind)),
        .probe_addr (req_addr),
        .commit     (accept),
        .need_ale   (need_ale)
    );

    ebs_len_sel #(.LW(LW)) len_i (
        .kind     (req_kind),
        .cfg_code (cfg_code_len),
        .cfg_rd   (cfg_rd_len),
        .cfg_wr   (cfg_wr_len),
        .len      (len)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (accept) begin
                    s_d.wr    = kind_is_write(req_kind);
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                    s_d.cnt   = len;
                    s_d.st    = need_ale ? ST_ADDR : ST_STRB;
                end
            end
            ST_ADDR: begin
                s_d.st = ST_STRB;
            end
            ST_STRB: begin
                if (s_q.cnt == LW'(1)) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    if (!s_q.wr) s_d.rdata = bus_in;
                end else begin
                    s_d.cnt = s_q.cnt - LW'(1);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_ale = (s_q.st == ST_ADDR);
        bus_rd  = (s_q.st == ST_STRB) && !s_q.wr;
        bus_wr  = (s_q.st == ST_STRB) &&  s_q.wr;
        bus_oe  = bus_ale || bus_wr;
        if (bus_ale)     bus_out = DW'(s_q.addr);
        else if (bus_wr) bus_out = s_q.wdata;
        else             bus_out = '0;
    end

    assign done  = s_q.done;
    assign rdata = s_q.rdata;
endmodule

// File: rtl/ebs_checker.sv
module ebs_checker #(
    parameter int DW = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_kind,
    input logic       done,
    input logic       bus_ale,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       bus_oe
);
    p_ale_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);
    p_ale_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (!bus_rd && !bus_wr && bus_oe));
    p_ale_then_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> (bus_rd || bus_wr));
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    p_wr_drives_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> bus_oe);
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_rd || bus_wr));
    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale || bus_rd || bus_wr) |-> !req_ready);
    p_data_gets_ale_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind != 2'b00) |=> bus_ale);
endmodule

bind ext_bus_seq ebs_checker #(.DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .done      (done),
    .bus_ale   (bus_ale),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_oe    (bus_oe)
);

// File: tb/ext_bus_seq_tb_top.sv
module ext_bus_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'b00;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  cfg_code_len = 4'd1;
    logic [3:0]  cfg_rd_len = 4'd2;
    logic [3:0]  cfg_wr_len = 4'd3;
    logic        done;
    logic [15:0] rdata;
    logic        bus_ale, bus_rd, bus_wr, bus_oe;
    logic [15:0] bus_out;
    logic [15:0] bus_in = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // bench model of the latched code window
    logic        m_live = 1'b0;
    logic [11:0] m_tag = '0;
    logic [15:0] m_next = '0;

    always #10 clk = ~clk;  // 50 MHz
    always @(posedge clk) cycles <= cycles + 1;

    ext_bus_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_code_len(cfg_code_len), .cfg_rd_len(cfg_rd_len), .cfg_wr_len(cfg_wr_len),
        .done(done), .rdata(rdata),
        .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [1:0] k);
        logic [3:0] v;
        v = k[1] ? cfg_wr_len : (k == 2'b00 ? cfg_code_len : cfg_rd_len);
        return (v == 0) ? 1 : int'(v);
    endfunction

    // which requirement decides the latch phase of this request
    function automatic string ale_reason(input logic [1:0] k, input logic [15:0] a);
        if (k != 2'b00)                   return "R6";
        if (!m_live)                      return "R2";
        if ({a[15:1], 1'b0} != m_next)    return "R5";
        if (a[15:4] != m_tag)             return "R4";
        return "R3";
    endfunction

    // called at a negedge with the sequencer idle; returns at a negedge
    task automatic txn(input logic [1:0] k, input logic [15:0] a, input logic [15:0] w);
        string reason;
        int    want_ale, want_len;
        int    ale_n = 0, strb_n = 0, last_strb = -1, done_at = -1, cyc = 0;
        bit    order_ok = 1, addr_ok = 1, wdat_ok = 1, kind_ok = 1;
        logic [15:0] exp_rd = '0;

        reason   = ale_reason(k, a);
        want_ale = (reason == "R3") ? 0 : 1;
        want_len = exp_len(k);

        req_kind = k; req_addr = a; req_wdata = w; req_valid = 1'b1;
        check(req_ready === 1'b1, "R11", "ready when idle", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;

        if (k == 2'b00) begin
            m_live = 1'b1; m_tag = a[15:4]; m_next = {a[15:1], 1'b0} + 16'd2;
        end else begin
            m_live = 1'b0;
        end

        while (done !== 1'b1 && cyc < 40) begin
            if (bus_ale) begin
                ale_n++;
                if (strb_n > 0) order_ok = 0;
                if (bus_out !== a || bus_oe !== 1'b1) addr_ok = 0;
            end
            if (bus_rd || bus_wr) begin
                strb_n++;
                last_strb = cyc;
                if (k[1] && (bus_wr !== 1'b1 || bus_out !== w || bus_oe !== 1'b1)) wdat_ok = 0;
                if (!k[1] && bus_rd !== 1'b1) kind_ok = 0;
            end
            bus_in = 16'($urandom);
            if (bus_rd) exp_rd = bus_in;
            cyc++;
            @(negedge clk);
        end
        done_at = cyc;

        check(ale_n == want_ale, reason, "latch phase count", ale_n, want_ale);
        check(order_ok && addr_ok, "R7", "latch phase address/order", addr_ok, 1);
        check(want_ale == 0 || ale_n != 1 || last_strb == strb_n, "R7",
              "strobe right after latch", last_strb, strb_n);
        check(want_ale == 1 || last_strb == strb_n - 1, "R3",
              "strobe starts right after accept", last_strb, strb_n - 1);
        check(strb_n == want_len, "R8", "strobe length", strb_n, want_len);
        check(kind_ok, "R9", "read strobe kind", kind_ok, 1);
        if (k[1]) check(wdat_ok, "R9", "write data on bus", wdat_ok, 1);
        check(done === 1'b1 && done_at == last_strb + 1, "R11", "done timing", done_at, last_strb + 1);
        if (!k[1]) check(rdata === exp_rd, "R10", "read data", rdata, exp_rd);
        @(negedge clk);
        check(done === 1'b0, "R11", "done one clock", done, 0);
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected<150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        check(req_ready === 1'b1 && !bus_ale && !bus_rd && !bus_wr && !bus_oe && !done,
              "R1", "held reset state", {req_ready, bus_ale, bus_rd, bus_wr, bus_oe, done}, 6'b100000);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && !bus_ale && !bus_rd && !bus_wr && !bus_oe && !done,
              "R1", "post reset state", {req_ready, bus_ale, bus_rd, bus_wr, bus_oe, done}, 6'b100000);

        // directed: first fetch (R2), then a full window run (R3), then a crossing (R4)
        cfg_code_len = 4'd0;  // zero clamps to one clock (R8)
        txn(2'b00, 16'h1230, 16'h0);
        for (int i = 1; i < 8; i++) txn(2'b00, 16'h1230 + 16'(2 * i), 16'h0);
        txn(2'b00, 16'h1240, 16'h0);
        // branch inside the same window (R5)
        txn(2'b00, 16'h1248, 16'h0);
        // data accesses clear the window (R6)
        cfg_rd_len = 4'd5; cfg_wr_len = 4'd15;
        txn(2'b01, 16'h8000, 16'h0);
        txn(2'b00, 16'h124A, 16'h0);
        txn(2'b10, 16'h8002, 16'hBEEF);
        txn(2'b11, 16'h8004, 16'h1357);
        txn(2'b00, 16'h124C, 16'h0);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [1:0]  k;
            logic [15:0] a;
            int          r;
            if ($urandom_range(0, 9) == 0) begin
                cfg_code_len = 4'($urandom_range(0, 15));
                cfg_rd_len   = 4'($urandom_range(0, 15));
                cfg_wr_len   = 4'($urandom_range(0, 15));
            end
            r = $urandom_range(0, 9);
            k = (r < 6) ? 2'b00 : 2'($urandom_range(1, 3));
            if (k == 2'b00 && m_live && $urandom_range(0, 3) != 0) a = m_next;
            else a = {15'($urandom), 1'b0};
            txn(k, a, 16'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule